// File: doc/BRIEF.md
# Counted-Loop Branch Unit

This functional unit lets a program on a move-only data bus run counted loops without any compare or branch instruction. The program sets up four registers by moving values to the unit's bus destinations: a loop limit, an index, a step and a loop-start address. Writing the index also records the current program-counter value as the loop-start address. A typical setup writes zero to the index, one to the step and the limit to the limit register.

At the bottom of the loop body the program moves the unit's branch subunit into the program counter. Each read of that subunit adds the step to the index. The value placed on the bus is the loop-start address if the updated index is still below the limit. Otherwise it is zero, which the sequencer treats as "no jump, fall through". The unit answers every access in the same bus cycle and never stalls the bus.

Top module: `loop_unit`

## Requirements
- R1: After reset the limit, index, step and start registers all read back as zero.
- R2: With `dst_we` high, `wdata` is stored at the clock edge into the register picked by `dst_sel`: 0 limit, 1 index, 2 step, 3 start. A register is read by setting `src_re` high and `src_sel` to the same code, and its value then appears on `rdata` in the same cycle.
- R3: Writing the index (code 1) also stores `cur_pc` into the start register at the same edge.
- R4: A read of the branch subunit (`src_sel` = 4) adds the step to the index at that clock edge, modulo 2^DATA_W.
- R5: During a branch read, `rdata` equals the start register when the updated index is below the limit, compared as unsigned numbers.
- R6: During a branch read, `rdata` is zero when the updated index is greater than or equal to the limit (unsigned).
- R7: A write with `dst_sel` 4 to 7, or any cycle with `dst_we` low, changes no register.
- R8: `stall` is always low.
- R9: `rdata` is zero when `src_re` is low or when `src_sel` is 5 to 7, and such a cycle does not change the index.
- R10: If a branch read and an index write fall in the same cycle, the index takes the written value and the step is not added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the destination edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dst_we | input | 1 | Bus destination strobe for this unit |
| dst_sel | input | 3 | Destination subunit code |
| wdata | input | DATA_W | Bus data to be written |
| cur_pc | input | DATA_W | Program-counter value captured on an index write |
| src_re | input | 1 | Unit selected as bus source |
| src_sel | input | 3 | Source subunit code |
| rdata | output | DATA_W | Value driven onto the bus |
| stall | output | 1 | Bus stall request, tied low |

## Verification
The bench runs a full three-pass loop and checks that exactly the last branch read returns zero. A design with an off-by-one compare would jump one time too many or too few. Limits and indices above the sign bit are used, so a signed compare would give the wrong target, and an index that wraps past 2^32 checks the modular add. The bench also covers a branch read that collides with an index write, where a wrong priority would leave an incremented index. It checks that writes to the read-only branch code and to unmapped codes change nothing, which catches a decoder that aliases those codes onto real registers.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic [2:0] {
    SUB_LIMIT  = 3'd0,
    SUB_INDEX  = 3'd1,
    SUB_STEP   = 3'd2,
    SUB_START  = 3'd3,
    SUB_BRANCH = 3'd4
  } sub_e;
  localparam int SEL_W = 3;
endpackage

// File: rtl/loop_regs.sv
module loop_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cap_pc,
  input  logic              adv,
  input  logic [DATA_W-1:0] adv_idx,
  output logic [DATA_W-1:0] lim_q,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] step_q,
  output logic [DATA_W-1:0] start_q
);
  import loop_pkg::*;

  logic wr_lim, wr_idx, wr_step, wr_start;
  assign wr_lim   = wr_en && (wr_sel == SUB_LIMIT);
  assign wr_idx   = wr_en && (wr_sel == SUB_INDEX);
  assign wr_step  = wr_en && (wr_sel == SUB_STEP);
  assign wr_start = wr_en && (wr_sel == SUB_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '0;
      idx_q   <= '0;
      step_q  <= '0;
      start_q <= '0;
    end else begin
      if (wr_lim)  lim_q  <= wr_data;
      if (wr_step) step_q <= wr_data;
      // an index write wins over a branch advance
      if (wr_idx)   idx_q <= wr_data;
      else if (adv) idx_q <= adv_idx;
      if (wr_idx)        start_q <= cap_pc;
      else if (wr_start) start_q <= wr_data;
    end
  end
endmodule

// File: rtl/loop_step.sv
module loop_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] step,
  input  logic [DATA_W-1:0] lim,
  input  logic [DATA_W-1:0] start,
  output logic [DATA_W-1:0] nxt_idx,
  output logic              more,
  output logic [DATA_W-1:0] target
);
  function automatic logic [DATA_W-1:0] add_step(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic below(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return a < b;
  endfunction

  assign nxt_idx = add_step(idx, step);
  assign more    = below(nxt_idx, lim);
  assign target  = more ? start : '0;
endmodule

// File: rtl/loop_rdmux.sv
module loop_rdmux #(
  parameter int DATA_W = 32
) (
  input  logic              re,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] lim,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] step,
  input  logic [DATA_W-1:0] start,
  input  logic [DATA_W-1:0] target,
  output logic [DATA_W-1:0] q
);
  import loop_pkg::*;

  always_comb begin
    q = '0;
    if (re) begin
      case (sel)
        SUB_LIMIT:  q = lim;
        SUB_INDEX:  q = idx;
        SUB_STEP:   q = step;
        SUB_START:  q = start;
        SUB_BRANCH: q = target;
        default:    q = '0;
      endcase
    end
  end
endmodule

// File: rtl/loop_unit.sv
module loop_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_we,
  input  logic [2:0]        dst_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_pc,
  input  logic              src_re,
  input  logic [2:0]        src_sel,
  output logic [DATA_W-1:0] rdata,
  output logic              stall
);
  import loop_pkg::*;

  logic [DATA_W-1:0] lim_q, idx_q, step_q, start_q;
  logic [DATA_W-1:0] nxt_idx, target;
  logic              more;

  // named events for the checker
  logic br_rd, idx_wr;
  assign br_rd  = src_re && (src_sel == SUB_BRANCH);
  assign idx_wr = dst_we && (dst_sel == SUB_INDEX);

  loop_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dst_we), .wr_sel(dst_sel), .wr_data(wdata), .cap_pc(cur_pc),
    .adv(br_rd), .adv_idx(nxt_idx),
    .lim_q(lim_q), .idx_q(idx_q), .step_q(step_q), .start_q(start_q)
  );

  loop_step #(.DATA_W(DATA_W)) u_step (
    .idx(idx_q), .step(step_q), .lim(lim_q), .start(start_q),
    .nxt_idx(nxt_idx), .more(more), .target(target)
  );

  loop_rdmux #(.DATA_W(DATA_W)) u_mux (
    .re(src_re), .sel(src_sel),
    .lim(lim_q), .idx(idx_q), .step(step_q), .start(start_q),
    .target(target), .q(rdata)
  );

  assign stall = 1'b0;
endmodule

// File: rtl/loop_unit_chk.sv
module loop_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dst_we,
  input logic [2:0]        dst_sel,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] cur_pc,
  input logic              src_re,
  input logic [2:0]        src_sel,
  input logic [DATA_W-1:0] rdata,
  input logic              stall,
  input logic [DATA_W-1:0] idx_q,
  input logic [DATA_W-1:0] step_q,
  input logic [DATA_W-1:0] lim_q,
  input logic [DATA_W-1:0] start_q,
  input logic              br_rd,
  input logic              idx_wr
);
  // R8
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) !stall);

  // R3
  pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (start_q == $past(cur_pc)) && (idx_q == $past(wdata)));

  // R4
  index_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_rd && !idx_wr) |=> idx_q == $past(idx_q) + $past(step_q));

  // R5
  branch_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_rd |-> (rdata == start_q) || (rdata == '0));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_re |-> rdata == '0);

  // R9
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_rd && !idx_wr) |=> $stable(idx_q));

  // R7
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_we && dst_sel == 3'd0) |=> $stable(lim_q));
endmodule

bind loop_unit loop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_we(dst_we), .dst_sel(dst_sel),
  .wdata(wdata), .cur_pc(cur_pc), .src_re(src_re), .src_sel(src_sel),
  .rdata(rdata), .stall(stall), .idx_q(idx_q), .step_q(step_q),
  .lim_q(lim_q), .start_q(start_q), .br_rd(br_rd), .idx_wr(idx_wr)
);

// File: tb/sim_loop_unit.sv
module sim_loop_unit;
  localparam int W = 32;
  logic clk = 0;
  logic rst_n = 0;
  logic dst_we = 0;
  logic [2:0] dst_sel = 0;
  logic [W-1:0] wdata = 0, cur_pc = 0;
  logic src_re = 0;
  logic [2:0] src_sel = 0;
  logic [W-1:0] rdata;
  logic stall;
  int checks = 0, fails = 0;
  logic done = 0;

  always #10 clk = ~clk;

  loop_unit #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dst_we(dst_we), .dst_sel(dst_sel),
    .wdata(wdata), .cur_pc(cur_pc), .src_re(src_re), .src_sel(src_sel),
    .rdata(rdata), .stall(stall)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive after negedge, sample before next posedge
  task automatic cyc(input logic we, input logic [2:0] ds, input logic [W-1:0] d,
                     input logic [W-1:0] pc, input logic re, input logic [2:0] ss,
                     output logic [W-1:0] q);
    @(negedge clk);
    dst_we = we; dst_sel = ds; wdata = d; cur_pc = pc;
    src_re = re; src_sel = ss;
    #2 q = rdata;
    @(posedge clk);
    #1 dst_we = 0; src_re = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] pc);
    logic [W-1:0] q;
    cyc(1, a, d, pc, 0, 0, q);
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] q);
    cyc(0, 0, 0, 0, 1, a, q);
  endtask

  function automatic logic [W-1:0] model_target(input logic [W-1:0] i, s, l, st);
    logic [W-1:0] n;
    n = i + s;
    if (n < l) return st;
    return '0;
  endfunction

  task automatic t_reset();
    logic [W-1:0] q;
    for (int a = 0; a < 4; a++) begin
      rd(a[2:0], q); check("R1 reset value", q, 0);
    end
    check("R8 stall", {31'd0, stall}, 0);
  endtask

  task automatic t_rw();
    logic [W-1:0] q;
    wr(0, 32'hA5A5_0001, 0);
    wr(2, 32'h0000_0003, 0);
    wr(3, 32'hDEAD_0400, 0);
    rd(0, q); check("R2 limit readback", q, 32'hA5A5_0001);
    rd(2, q); check("R2 step readback", q, 32'h3);
    rd(3, q); check("R2 start readback", q, 32'hDEAD_0400);
    wr(1, 32'h77, 32'h0000_1230);
    rd(1, q); check("R2 index readback", q, 32'h77);
    rd(3, q); check("R3 start captured from pc", q, 32'h1230);
  endtask

  task automatic t_loop();
    logic [W-1:0] q;
    wr(0, 3, 0);
    wr(2, 1, 0);
    wr(1, 0, 32'h100);
    rd(4, q); check("R5 pass 1 jumps back", q, 32'h100);
    rd(4, q); check("R5 pass 2 jumps back", q, 32'h100);
    rd(4, q); check("R6 pass 3 falls through", q, 0);
    rd(1, q); check("R4 index after three reads", q, 3);
    rd(4, q); check("R6 past limit stays zero", q, 0);
    rd(1, q); check("R4 index keeps stepping", q, 4);
  endtask

  task automatic t_unsigned();
    logic [W-1:0] q;
    wr(0, 32'h8000_0000, 0);
    wr(2, 1, 0);
    wr(1, 32'h7FFF_FFFF, 32'h200);
    rd(4, q); check("R6 equal to limit at sign bit", q,
                    model_target(32'h7FFF_FFFF, 1, 32'h8000_0000, 32'h200));
    wr(0, 32'h9000_0000, 0);
    wr(2, 2, 0);
    wr(1, 5, 32'h300);
    rd(4, q); check("R5 unsigned limit above sign bit", q, 32'h300);
    wr(0, 5, 0);
    wr(1, 32'hFFFF_FFFF, 32'h340);
    rd(4, q); check("R5 wrapped index below limit", q,
                    model_target(32'hFFFF_FFFF, 2, 5, 32'h340));
    rd(1, q); check("R4 modular add", q, 1);
  endtask

  task automatic t_ignore();
    logic [W-1:0] q;
    wr(0, 10, 0);
    wr(2, 4, 0);
    wr(1, 2, 32'h500);
    for (int a = 4; a < 8; a++) begin
      wr(a[2:0], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    end
    cyc(0, 0, 32'h1234, 32'h999, 0, 0, q);
    cyc(0, 1, 32'h1234, 32'h999, 0, 0, q);
    check("R9 no source selected", q, 0);
    rd(0, q); check("R7 limit untouched", q, 10);
    rd(1, q); check("R7 index untouched", q, 2);
    rd(2, q); check("R7 step untouched", q, 4);
    rd(3, q); check("R7 start untouched", q, 32'h500);
    rd(5, q); check("R9 unmapped source", q, 0);
    rd(7, q); check("R9 unmapped source 7", q, 0);
    rd(1, q); check("R9 index unchanged by unmapped read", q, 2);
  endtask

  task automatic t_collide();
    logic [W-1:0] q;
    cyc(1, 1, 32'h40, 32'h600, 1, 4, q);
    check("R5 colliding read uses old state", q, 32'h500);
    rd(1, q); check("R10 write wins over advance", q, 32'h40);
    rd(3, q); check("R10 start from pc", q, 32'h600);
    check("R8 stall stays low", {31'd0, stall}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_rw();
    t_loop();
    t_unsigned();
    t_ignore();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule